// File: doc/BRIEF.md
# Carry-Select Adder with Prefix Groups and Increment Correction

This block adds two unsigned WIDTH-bit operands and a carry-in, giving a WIDTH-bit sum and a carry-out. It is purely combinational: there is no clock, no register and no handshake. Results follow the inputs within one settling time.

The operands are cut into 4-bit slices. The lowest slice is a 4-bit Kogge-Stone prefix adder driven straight by the external carry-in. Each higher slice speculates. Its own Kogge-Stone adder runs with a carry-in of zero and forms a 5-bit partial result (carry, four sum bits). An incrementer then turns that partial result into the carry-in-of-one version. The incrementer is a binary-to-excess-1 converter, which needs far fewer gates than a second adder. The carry leaving the slice below picks one of the two 5-bit results.

WIDTH must be a multiple of 4. The default is 64, which gives 16 slices and a 15-stage select chain.

Top module: `ksbec_adder`

## Requirements
- R1: For every input, {cout, sum} equals the full (WIDTH+1)-bit value a + b + cin.
- R2: The carry passed from slice k to slice k+1 equals bit 4(k+1) of the reference sum of the low 4(k+1) bits of a and b plus cin.
- R3: cin feeds the lowest slice directly. With a = 0, b = 0 and cin = 1, the outputs are sum = 1 and cout = 0.
- R4: With a all ones, b = 0 and cin = 1, the outputs are sum = 0 and cout = 1. The carry travels through every slice.
- R5: A carry produced in any slice moves across a boundary into a slice whose operand bits sum to 1111. That slice then gives sum bits 0000 and passes the carry on.
- R6: When a slice's operand nibbles are both 1111 and a carry enters it, that slice gives sum bits 1111 and a carry-out of 1.
- R7: With b = 0 and cin = 0, sum equals a and cout is 0.
- R8: cout equals the carry selected in the most significant slice. Outputs follow an input change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach from the ports is a long select chain. Here a carry made low in the word must pass through many slices that only propagate, so each of their selects flips from the zero-carry result to the incremented one. Random operands almost never produce runs of propagate slices, so the stimulus builds them on purpose. It uses an all-ones operand with a carry-in, a mask of ones ending at each slice boundary plus one, and operand pairs where b is the complement of a. Random vectors then cover the general case.

// File: rtl/ksbec_pkg.sv
package ksbec_pkg;
  localparam int SLICE_W = 4;
  localparam int SEL_W   = SLICE_W + 1;

  function automatic int slice_count(input int width);
    return width / SLICE_W;
  endfunction
endpackage

// File: rtl/ksbec_prefix_add.sv
module ksbec_prefix_add #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         co
);
  localparam int LV = $clog2(W);

  logic [LV:0][W-1:0] gen;
  logic [LV:0][W-1:0] prp;
  logic [W:0]         c;

  // pre-processing, prefix levels at distances 1, 2, 4 ..., then carries
  always_comb begin
    gen[0] = a & b;
    prp[0] = a ^ b;
    for (int l = 0; l < LV; l++) begin
      for (int i = 0; i < W; i++) begin
        if (i >= (1 << l)) begin
          gen[l+1][i] = gen[l][i] | (prp[l][i] & gen[l][i - (1 << l)]);
          prp[l+1][i] = prp[l][i] & prp[l][i - (1 << l)];
        end else begin
          gen[l+1][i] = gen[l][i];
          prp[l+1][i] = prp[l][i];
        end
      end
    end
    c[0] = cin;
    for (int i = 0; i < W; i++) begin
      c[i+1] = gen[LV][i] | (prp[LV][i] & cin);
    end
  end

  assign s  = prp[0] ^ c[W-1:0];
  assign co = c[W];
endmodule

// File: rtl/ksbec_excess1.sv
module ksbec_excess1 #(
  parameter int N = 5
) (
  input  logic [N-1:0] v,
  output logic [N-1:0] x
);
  logic [N-1:0] run;

  always_comb begin
    run[0] = 1'b1;
    for (int i = 1; i < N; i++) begin
      run[i] = run[i-1] & v[i-1];
    end
  end

  assign x = v ^ run;
endmodule

// File: rtl/ksbec_group.sv
module ksbec_group
  import ksbec_pkg::*;
#(
  parameter bit BASE = 1'b0
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               ci,
  output logic [SLICE_W-1:0] s,
  output logic               co
);
  generate
    if (BASE) begin : g_base
      ksbec_prefix_add #(.W(SLICE_W)) u_add (
        .a(a), .b(b), .cin(ci), .s(s), .co(co)
      );
    end else begin : g_spec
      logic [SLICE_W-1:0] s0;
      logic               c0;
      logic [SEL_W-1:0]   res0;
      logic [SEL_W-1:0]   res1;

      ksbec_prefix_add #(.W(SLICE_W)) u_add (
        .a(a), .b(b), .cin(1'b0), .s(s0), .co(c0)
      );
      assign res0 = {c0, s0};
      ksbec_excess1 #(.N(SEL_W)) u_inc (
        .v(res0), .x(res1)
      );
      assign {co, s} = ci ? res1 : res0;
    end
  endgenerate
endmodule

// File: rtl/ksbec_adder.sv
module ksbec_adder
  import ksbec_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NGRP = slice_count(WIDTH);

  logic [NGRP:0] grp_carry;

  assign grp_carry[0] = cin;

  generate
    for (genvar k = 0; k < NGRP; k++) begin : g_slice
      ksbec_group #(.BASE(k == 0)) u_grp (
        .a (a[k*SLICE_W +: SLICE_W]),
        .b (b[k*SLICE_W +: SLICE_W]),
        .ci(grp_carry[k]),
        .s (sum[k*SLICE_W +: SLICE_W]),
        .co(grp_carry[k+1])
      );
    end
  endgenerate

  assign cout = grp_carry[NGRP];
endmodule

// File: rtl/ksbec_adder_chk.sv
module ksbec_adder_chk #(
  parameter int WIDTH = 64,
  parameter int NGRP  = WIDTH / 4
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [NGRP:0]    grp_carry
);
  logic [WIDTH:0] ref_full;
  logic [WIDTH:0] msk;
  logic [WIDTH:0] low_sum;

  assign ref_full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    AST_EXACT_SUM: assert ({cout, sum} == ref_full)
      else $error("exact sum mismatch"); // R1
    if (b == '0 && !cin) begin
      AST_ZERO_ADDEND: assert (sum == a && !cout)
        else $error("zero addend changed a"); // R7
    end
    if (a == '1 && b == '0 && cin) begin
      AST_ALLONES_WRAP: assert (sum == '0 && cout)
        else $error("all-ones wrap wrong"); // R4
    end
    AST_COUT_TOP: assert (cout == grp_carry[NGRP])
      else $error("cout not top carry"); // R8
    msk     = '0;
    low_sum = '0;
    for (int k = 0; k < NGRP; k++) begin
      msk     = ({{WIDTH{1'b0}}, 1'b1} << (4 * (k + 1))) - {{WIDTH{1'b0}}, 1'b1};
      low_sum = ({1'b0, a} & msk) + ({1'b0, b} & msk) + {{WIDTH{1'b0}}, cin};
      AST_SLICE_CARRY: assert (grp_carry[k+1] == low_sum[4*(k+1)])
        else $error("slice carry %0d wrong", k); // R2
    end
  end
endmodule

bind ksbec_adder ksbec_adder_chk #(.WIDTH(WIDTH), .NGRP(NGRP)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .grp_carry(grp_carry)
);

// File: tb/ksbec_adder_test.sv
module ksbec_adder_test;
  localparam int  WIDTH      = 64;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NGRP       = WIDTH / 4;

  logic             clk = 1'b0;
  logic [WIDTH-1:0] a = '0;
  logic [WIDTH-1:0] b = '0;
  logic             cin = 1'b0;
  logic [WIDTH-1:0] sum;
  logic             cout;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ksbec_adder #(.WIDTH(WIDTH)) uut (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  task automatic compare(input string req, input logic [WIDTH:0] expv);
    n_checks++;
    if ({cout, sum} !== expv) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, {cout, sum}, expv);
    end
  endtask

  // drive on rising edge, check on falling edge against behavioural '+'
  task automatic apply(input logic [WIDTH-1:0] av, input logic [WIDTH-1:0] bv,
                       input logic cv, input string req);
    logic [WIDTH:0] expv;
    @(posedge clk);
    a = av; b = bv; cin = cv;
    expv = {1'b0, av} + {1'b0, bv} + {{WIDTH{1'b0}}, cv};
    @(negedge clk);
    compare(req, expv);
  endtask

  function automatic logic [WIDTH-1:0] rnd();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [WIDTH-1:0] ones_lo;
    // R7: reset-like all-zero state and zero addend
    apply('0, '0, 1'b0, "R7 zero");
    apply(64'h0123_4567_89AB_CDEF, '0, 1'b0, "R7 a plus zero");
    // R3: carry-in reaches bit 0
    apply('0, '0, 1'b1, "R3 cin only");
    // R4: all ones plus one
    apply('1, '0, 1'b1, "R4 ones plus cin");
    apply('1, {{(WIDTH-1){1'b0}}, 1'b1}, 1'b0, "R4 ones plus b one");
    // R5 and R2: carry crossing each slice boundary
    for (int k = 0; k < NGRP; k++) begin
      ones_lo = ({{(WIDTH-1){1'b0}}, 1'b1} << (4 * k + 4)) - 1;
      if (k == NGRP - 1) ones_lo = '1;
      apply(ones_lo, {{(WIDTH-1){1'b0}}, 1'b1}, 1'b0, "R5 R2 boundary ripple");
    end
    // R6: both nibbles 1111 with carry entering
    apply('1, '1, 1'b1, "R6 max slices cin");
    apply('1, '1, 1'b0, "R6 max slices");
    apply(64'hF0F0_F0F0_F0F0_F0FF, 64'hF0F0_F0F0_F0F0_F0F1, 1'b0, "R6 alternating max");
    // long propagate chains: b is complement of a
    for (int i = 0; i < 200; i++) begin
      logic [WIDTH-1:0] r;
      r = rnd();
      apply(r, ~r, i[0], "R2 propagate chain");
    end
    // R8: outputs follow inputs with no clock edge
    @(negedge clk);
    a = '1; b = '0; cin = 1'b1;
    #1;
    compare("R8 no clock", {1'b1, {WIDTH{1'b0}}});
    a = 64'h8000_0000_0000_0000; b = 64'h8000_0000_0000_0000; cin = 1'b0;
    #1;
    compare("R8 top carry", {1'b1, {WIDTH{1'b0}}});
    // R1: random vectors
    for (int i = 0; i < 10000; i++) begin
      apply(rnd(), rnd(), $urandom_range(1, 0) == 1, "R1 random");
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule